// File: doc/BRIEF.md
# Strobe-Synchronized Byte-to-Serial Bridge

The bridge carries a stream of bytes from a slow byte clock to a bit-serial output in an unrelated, faster clock domain without any FIFO. In the slow domain, every falling edge of the byte clock writes one byte into a lane of a six-lane assembly register. When the last lane is filled, the complete word is copied into a holding register. A slow-domain level strobe stays high during the second half of each group of six bytes. During that time the holding register is guaranteed not to change.

In the fast domain, the strobe passes through a two-flop synchronizer. A rising-edge detector then turns it into a load enable that is exactly one cycle wide. This enable copies the held word into a shift register in parallel. The shift register then sends the word out least significant bit first, one bit per fast clock, with a valid flag. The source gets no back-pressure, and nothing checks the clock ratio. The fast clock must be quick enough to send a whole word in fewer fast cycles than one group of six bytes takes to arrive.

Top module: `strobe_serial_bridge`

## Requirements
- R1: A byte is captured on each falling edge of `byteClk`. Within a word, the first byte of a group takes bits 7:0 and each following byte takes the next higher 8 bits, ending at bits 47:40.
- R2: The lane counter counts lanes 0 to 5 and wraps from 5 back to 0. Reset returns it to lane 0, so the first byte after reset becomes bits 7:0 of a word.
- R3: The slow strobe is low while lanes 0 to 2 are being filled and high while lanes 3 to 5 are being filled. A load therefore follows the capture that brings the total number of captured bytes to 9, 15, 21 and so on.
- R4: The strobe stays low until a first complete word has been committed. No load, and no assertion of `serValid`, happens before the ninth byte after reset.
- R5: The strobe crosses through two flip-flops in series. A rising-edge detector then produces a load pulse exactly one fast cycle wide. `serValid` rises no more than four fast periods after the capture that raised the strobe.
- R6: The holding register is written only when lane 5 is captured, and it stays stable while the strobe is high. Each serialized word therefore equals a fully assembled word and never a partly built one.
- R7: After a load, `serOut` presents bit 0 of the word, then one more significant bit per fast clock. `serValid` stays high for exactly 48 fast cycles and rises only after a load.
- R8: `rst` is asynchronous and active high. While it is high, `serValid` and `serOut` are 0, and the lane counter, the strobe, the synchronizer, the edge detector and the shift register are cleared.
- R9: Serialized words appear in the same order as they were assembled, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| byteClk | input | 1 | Slow byte clock; bytes are captured on its falling edge |
| byteIn | input | 8 | Byte data bus |
| fastClk | input | 1 | Fast serial clock |
| serOut | output | 1 | Serial data bit, least significant bit first |
| serValid | output | 1 | High while `serOut` carries a word bit |

## Verification
The bound checker watches the control on every cycle:
- the lane counter stepping and wrapping;
- the held word staying unchanged except at a lane-5 capture;
- the load pulse being one cycle wide;
- `serValid` rising only after a load and lasting exactly 48 cycles.

Only the bench's scenarios can show the rest. These are the bit order and value of each word against bytes driven on the bus, and the alignment of loads to the 9th, 15th and later captures. They also include the crossing latency, order with no loss or repetition across three data patterns, and a restart from lane 0 after a reset in mid-word.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int BYTE_BITS = 8;
  localparam int WORD_LANES = 6;

  // Slow-domain control strobes toward the word assembler.
  typedef struct packed {
    logic commit;   // lane being captured is the last one: copy word to hold
  } slowStrobes_t;

  // Fast-domain control strobes toward the shifter.
  typedef struct packed {
    logic load;     // single-cycle parallel load enable
    logic shift;    // advance one bit
  } fastStrobes_t;

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int LANES  = WORD_LANES,
  parameter int WORD_W = BYTE_BITS * WORD_LANES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W  = $clog2(WORD_W + 1),
  localparam int HALF_LANE = LANES / 2
) (
  input  logic              rst,
  input  logic              byteClk,
  input  logic              fastClk,
  output logic [LANE_W-1:0] lanePos,
  output slowStrobes_t      slowCtl,
  output fastStrobes_t      fastCtl,
  output logic              serValid
);

  // ---------------- slow domain ----------------
  logic [LANE_W-1:0] laneNext;
  logic              primed;
  logic              primedNext;
  logic              strobeSlow;
  logic              atLast;

  assign atLast     = (lanePos == LANE_W'(LANES - 1));
  assign laneNext   = atLast ? '0 : lanePos + 1'b1;
  assign primedNext = primed | atLast;
  assign slowCtl.commit = atLast;

  always_ff @(negedge byteClk or posedge rst) begin
    if (rst) begin
      lanePos    <= '0;
      primed     <= 1'b0;
      strobeSlow <= 1'b0;
    end else begin
      lanePos    <= laneNext;
      primed     <= primedNext;
      strobeSlow <= primedNext && (laneNext >= LANE_W'(HALF_LANE));
    end
  end

  // ---------------- fast domain ----------------
  logic syncA;
  logic syncB;
  logic syncSeen;
  logic [CNT_W-1:0] bitsLeft;

  always_ff @(posedge fastClk or posedge rst) begin
    if (rst) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncSeen <= 1'b0;
    end else begin
      syncA    <= strobeSlow;
      syncB    <= syncA;
      syncSeen <= syncB;
    end
  end

  assign fastCtl.load  = syncB & ~syncSeen;
  assign fastCtl.shift = (bitsLeft != '0) & ~fastCtl.load;
  assign serValid      = (bitsLeft != '0);

  always_ff @(posedge fastClk or posedge rst) begin
    if (rst) begin
      bitsLeft <= '0;
    end else if (fastCtl.load) begin
      bitsLeft <= CNT_W'(WORD_W);
    end else if (bitsLeft != '0) begin
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import bridge_pkg::*;
#(
  parameter int BYTE_W = BYTE_BITS,
  parameter int LANES  = WORD_LANES,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              rst,
  input  logic              byteClk,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [LANE_W-1:0] lanePos,
  input  slowStrobes_t      slowCtl,
  output logic [WORD_W-1:0] heldWord
);

  logic [WORD_W-1:0] buildWord;
  logic [WORD_W-1:0] buildNext;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign buildNext[g*BYTE_W +: BYTE_W] =
      (lanePos == LANE_W'(g)) ? byteIn : buildWord[g*BYTE_W +: BYTE_W];
  end

  always_ff @(negedge byteClk or posedge rst) begin
    if (rst) begin
      buildWord <= '0;
      heldWord  <= '0;
    end else begin
      buildWord <= buildNext;
      if (slowCtl.commit) heldWord <= buildNext;
    end
  end

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import bridge_pkg::*;
#(
  parameter int WORD_W = BYTE_BITS * WORD_LANES
) (
  input  logic              rst,
  input  logic              fastClk,
  input  logic [WORD_W-1:0] heldWord,
  input  fastStrobes_t      fastCtl,
  output logic              serOut
);

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge fastClk or posedge rst) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (fastCtl.load) begin
      shiftReg <= heldWord;
    end else if (fastCtl.shift) begin
      shiftReg <= {1'b0, shiftReg[WORD_W-1:1]};
    end
  end

  assign serOut = shiftReg[0];

endmodule

// File: rtl/strobe_serial_bridge.sv
module strobe_serial_bridge
  import bridge_pkg::*;
#(
  parameter int BYTE_W = BYTE_BITS,
  parameter int LANES  = WORD_LANES,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              rst,
  input  logic              byteClk,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              fastClk,
  output logic              serOut,
  output logic              serValid
);

  logic [LANE_W-1:0] lanePos;
  slowStrobes_t      slowCtl;
  fastStrobes_t      fastCtl;
  logic [WORD_W-1:0] heldWord;

  bridge_ctrl #(.LANES(LANES), .WORD_W(WORD_W)) u_ctrl (
    .rst(rst), .byteClk(byteClk), .fastClk(fastClk),
    .lanePos(lanePos), .slowCtl(slowCtl), .fastCtl(fastCtl),
    .serValid(serValid)
  );

  word_assembler #(.BYTE_W(BYTE_W), .LANES(LANES)) u_asm (
    .rst(rst), .byteClk(byteClk), .byteIn(byteIn),
    .lanePos(lanePos), .slowCtl(slowCtl), .heldWord(heldWord)
  );

  serial_shifter #(.WORD_W(WORD_W)) u_shift (
    .rst(rst), .fastClk(fastClk), .heldWord(heldWord),
    .fastCtl(fastCtl), .serOut(serOut)
  );

endmodule

// File: rtl/bridge_checks.sv
module bridge_checks
  import bridge_pkg::*;
#(
  parameter int LANES  = WORD_LANES,
  parameter int WORD_W = BYTE_BITS * WORD_LANES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int RUN_W  = $clog2(WORD_W + 1) + 1
) (
  input logic              rst,
  input logic              byteClk,
  input logic              fastClk,
  input logic [LANE_W-1:0] lanePos,
  input slowStrobes_t      slowCtl,
  input fastStrobes_t      fastCtl,
  input logic [WORD_W-1:0] heldWord,
  input logic              serValid
);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge fastClk or posedge rst) begin
    if (rst) runLen <= '0;
    else if (fastCtl.load) runLen <= '0;
    else if (serValid) runLen <= runLen + 1'b1;
  end

  // R2: lane counter wraps from the last lane to lane 0
  p_lane_wrap_r2: assert property (@(negedge byteClk) disable iff (rst)
    lanePos == LANE_W'(LANES - 1) |=> lanePos == '0);

  // R2: lane counter steps by one otherwise
  p_lane_step_r2: assert property (@(negedge byteClk) disable iff (rst)
    lanePos != LANE_W'(LANES - 1) |=> lanePos == $past(lanePos) + 1'b1);

  // R6: held word changes only at a commit
  p_held_stable_r6: assert property (@(negedge byteClk) disable iff (rst)
    !slowCtl.commit |=> $stable(heldWord));

  // R5: load pulse is one fast cycle wide
  p_load_single_r5: assert property (@(posedge fastClk) disable iff (rst)
    fastCtl.load |=> !fastCtl.load);

  // R7: valid follows a load
  p_valid_after_load_r7: assert property (@(posedge fastClk) disable iff (rst)
    fastCtl.load |=> serValid);

  // R7: valid never rises without a load
  p_valid_needs_load_r7: assert property (@(posedge fastClk) disable iff (rst)
    !serValid && !fastCtl.load |=> !serValid);

  // R7: each valid run is exactly one word long
  p_valid_len_r7: assert property (@(posedge fastClk) disable iff (rst)
    $fell(serValid) |-> runLen == RUN_W'(WORD_W));

endmodule

bind strobe_serial_bridge bridge_checks #(.LANES(LANES), .WORD_W(WORD_W)) u_checks (
  .rst(rst), .byteClk(byteClk), .fastClk(fastClk),
  .lanePos(lanePos), .slowCtl(slowCtl), .fastCtl(fastCtl),
  .heldWord(heldWord), .serValid(serValid)
);

// File: tb/sim_strobe_serial_bridge.sv
module sim_strobe_serial_bridge;

  localparam int FAST_PERIOD = 10;
  localparam int SLOW_PERIOD = 100;
  localparam int WORD_BITS   = 48;

  logic rst;
  logic byteClk;
  logic fastClk;
  logic [7:0] byteIn;
  logic serOut;
  logic serValid;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int wordsSeen = 0;

  strobe_serial_bridge u0 (
    .rst(rst), .byteClk(byteClk), .byteIn(byteIn),
    .fastClk(fastClk), .serOut(serOut), .serValid(serValid)
  );

  initial fastClk = 1'b0;
  always #(FAST_PERIOD/2) fastClk = ~fastClk;

  initial begin
    byteClk = 1'b0;
    #3;
    forever #(SLOW_PERIOD/2) byteClk = ~byteClk;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Byte source: new byte after each rising edge, captured on the falling edge.
  int byteNum = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge byteClk) begin
    byteNum++;
    case (mode)
      0: byteIn <= byteNum[7:0];
      1: byteIn <= byteNum[0] ? 8'hFF : 8'h00;
      default: begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        byteIn <= lfsr;
      end
    endcase
  end

  // Behavioural model of the slow side: a byte queue folded into words.
  logic [47:0] wordQ[$];
  logic [47:0] building;
  int lane = 0;
  int captures = 0;
  time lastCap = 0;
  bit freshReset = 1'b0;

  always @(negedge byteClk or posedge rst) begin
    if (rst) begin
      lane = 0; captures = 0; wordQ.delete(); building = '0;
    end else begin
      building[lane*8 +: 8] = byteIn;
      captures++;
      lastCap = $time;
      lane++;
      if (lane == 6) begin
        wordQ.push_back(building);
        lane = 0;
      end
    end
  end

  // Serial monitor, compared on every fast clock.
  int bitIdx = -1;
  logic [47:0] cur;
  logic [47:0] recv;
  string bitTag;

  always @(negedge fastClk) begin
    if (rst) begin
      bitIdx = -1;
      freshReset = 1'b1;
    end else if (serValid) begin
      if (bitIdx < 0) begin
        check(captures >= 9, "R4", captures, 9);
        check(captures % 6 == 3, "R3", captures % 6, 3);
        check(($time - lastCap) <= 4*FAST_PERIOD, "R5", $time - lastCap, 4*FAST_PERIOD);
        if (wordQ.size() == 0) begin
          check(1'b0, "R9", 0, 1);
          cur = '0;
        end else begin
          cur = wordQ.pop_front();
        end
        bitTag = freshReset ? "R2" : "R1";
        freshReset = 1'b0;
        recv = '0;
        bitIdx = 0;
      end
      if (bitIdx >= WORD_BITS) begin
        check(1'b0, "R7", bitIdx, WORD_BITS);
      end else begin
        check(serOut == cur[bitIdx], bitTag, serOut, cur[bitIdx]);
        recv[bitIdx] = serOut;
        bitIdx++;
      end
    end else if (bitIdx >= 0) begin
      check(bitIdx == WORD_BITS, "R7", bitIdx, WORD_BITS);
      check(recv == cur, "R6", recv, cur);
      wordsSeen++;
      bitIdx = -1;
    end
  end

  initial begin
    rst = 1'b1;
    byteIn = 8'h00;
    #25;
    check(serValid == 1'b0, "R8", serValid, 0);
    check(serOut == 1'b0, "R8", serOut, 0);
    @(posedge byteClk); #1 rst = 1'b0;

    mode = 0;
    repeat (200) @(posedge byteClk);
    mode = 1;
    repeat (100) @(posedge byteClk);

    // Reset in the middle of a word.
    wait (serValid == 1'b1);
    repeat (10) @(posedge fastClk);
    #2 rst = 1'b1;
    #1;
    check(serValid == 1'b0, "R8", serValid, 0);
    check(serOut == 1'b0, "R8", serOut, 0);
    repeat (5) @(posedge fastClk);
    check(serValid == 1'b0, "R8", serValid, 0);
    @(posedge byteClk); #1 rst = 1'b0;

    mode = 2;
    repeat (200) @(posedge byteClk);
    repeat (20) @(posedge fastClk);

    check(wordsSeen >= 75, "R9", wordsSeen, 75);
    check(wordQ.size() <= 1, "R9", wordQ.size(), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(FAST_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule